// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM with a 2K x 8 organisation. It turns one-cycle requests into correctly timed strobe sequences on the memory side. The host presents an address, a read/write select and write data with a valid pulse. The controller then owns the memory pins until the access and its recovery are complete. The memory has three active-low strobes: chip select, output enable and write strobe. Its data bus is split into an output value, an output-enable and an input value, so that the pad cell outside the block forms the tri-state buffer.

Every timing interval is set in nanoseconds and turned into clock counts at elaboration. Each count is the nanosecond figure divided by the clock period, rounded up. The intervals are:

- the read access time, which is the worst of the address, chip-select and output-enable access times;
- the write pulse, which is stretched to cover the data setup time;
- the data hold after the pulse;
- the recovery, which is stretched so that the memory has released the bus and the minimum cycle time is met.

A parameter selects which strobe controls a write. In the default, chip select falls first and the write strobe frames the transfer. In the alternative, the roles are swapped.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all three strobes are high (1), the data bus is not driven, busy is 0 and ack is 0.
- R2: A read that is accepted on a clock edge drives chip select and output enable low, and keeps the write strobe high, from that edge for exactly ACC cycles. ACC is the largest of the rounded address, chip-select and output-enable access times.
- R3: On the edge that ends the read access, the value on the data input is captured into rdata and ack pulses in the following cycle.
- R4: In the default write-strobe-controlled mode, the following sequence is produced:
  - chip select falls on the accept edge;
  - the write strobe falls one edge later and stays low for PULSE cycles, where PULSE is the larger of the rounded write-pulse and data-setup times;
  - the write strobe rises first;
  - chip select rises HOLD cycles after that.
- R5: Output enable is high whenever the write strobe is low, and the controller never drives the data bus while output enable is low.
- R6: The memory address is held constant from the accept edge until busy falls. Write data is driven, unchanged, from the accept edge until the write strobe rises.
- R7: The data bus is released on the same edge that raises the write strobe. It stays undriven through the hold and recovery intervals.
- R8: Busy is 1 from the accept edge until the recovery ends. During recovery all strobes are high.
  - After a read, recovery lasts the largest of the rounded recovery time, the bus-release time, and the cycle time minus ACC.
  - After a write, recovery lasts long enough for the whole cycle to reach the rounded cycle time, and is never less than the rounded recovery time.
- R9: A request presented while busy is 1 is ignored. It starts no access and changes neither the address nor the memory contents.
- R10: Every interval count equals the ceiling of its nanosecond value divided by the clock period, with a minimum of one cycle.
- R11: Ack is a single-cycle pulse, issued exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access or recovery in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Value read from the data bus |

## Verification
All intervals are counted from the accept edge, which is the first rising edge that sees the request.

For a read, the strobes are expected low up to edge ACC. Ack and rdata are due at that edge, and busy falls at edge ACC plus the read recovery.

For a write, the following are expected:

- the write strobe is low from edge 1 to edge PULSE;
- the bus is released and ack is raised at edge PULSE+1;
- chip select rises at edge PULSE+HOLD+1;
- busy falls after the write recovery.

The bench drives requests and samples every output on falling edges. It compares the full strobe, drive, busy and ack vector against these edge numbers in every cycle of every access, using counts it computes itself from the nanosecond figures.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      SC_IDLE     = 3'd0,
      SC_RD_ACC   = 3'd1,
      SC_WR_LEAD  = 3'd2,
      SC_WR_PULSE = 3'd3,
      SC_WR_HOLD  = 3'd4,
      SC_RECOV    = 3'd5
   } sc_state_e;

   // ceiling of ns / period, never below one cycle (R10)
   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_tmr.sv
module sram_phase_tmr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // the count only moves downward between loads (R10)
   AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ACC_CYC    = 7,
   parameter int PULSE_CYC  = 5,
   parameter int HOLD_CYC   = 1,
   parameter int RD_REC_CYC = 3,
   parameter int WR_REC_CYC = 1,
   parameter int CNT_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_zero,
   output sc_state_e        st_q,
   output sc_state_e        st_nxt,
   output logic             req_fire,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             rd_sample,
   output logic             ack_nxt
);

   assign req_fire  = req_valid && (st_q == SC_IDLE);
   assign rd_sample = (st_q == SC_RD_ACC) && tmr_zero;

   always_comb begin
      st_nxt   = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ack_nxt  = 1'b0;
      unique case (st_q)
         SC_IDLE: begin
            if (req_fire) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  st_nxt  = SC_WR_LEAD;
                  tmr_val = '0;
               end else begin
                  st_nxt  = SC_RD_ACC;
                  tmr_val = CNT_W'(ACC_CYC - 1);
               end
            end
         end
         SC_RD_ACC: begin
            if (tmr_zero) begin
               st_nxt   = SC_RECOV;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(RD_REC_CYC - 1);
               ack_nxt  = 1'b1;
            end
         end
         SC_WR_LEAD: begin
            if (tmr_zero) begin
               st_nxt   = SC_WR_PULSE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PULSE_CYC - 1);
            end
         end
         SC_WR_PULSE: begin
            if (tmr_zero) begin
               st_nxt   = SC_WR_HOLD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(HOLD_CYC - 1);
               ack_nxt  = 1'b1;
            end
         end
         SC_WR_HOLD: begin
            if (tmr_zero) begin
               st_nxt   = SC_RECOV;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(WR_REC_CYC - 1);
            end
         end
         SC_RECOV: begin
            if (tmr_zero) st_nxt = SC_IDLE;
         end
         default: st_nxt = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SC_IDLE;
      else        st_q <= st_nxt;
   end

   // a read access leaves only through recovery, never straight to idle (R8)
   AST_RD_TO_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SC_RD_ACC) |=> (st_q == SC_RD_ACC || st_q == SC_RECOV)); // R8

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
   import sram_ctrl_pkg::*;
#(
   parameter bit WE_CONTROLLED = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  sc_state_e st_nxt,
   output logic      ce_n,
   output logic      oe_n,
   output logic      we_n
);

   logic ce_d, we_d, oe_d;

   assign oe_d = !(st_nxt == SC_RD_ACC);

   generate
      if (WE_CONTROLLED) begin : g_we_frames
         // select leads, write strobe falls last and rises first
         assign ce_d = !(st_nxt == SC_RD_ACC  || st_nxt == SC_WR_LEAD ||
                         st_nxt == SC_WR_PULSE || st_nxt == SC_WR_HOLD);
         assign we_d = !(st_nxt == SC_WR_PULSE);
      end else begin : g_ce_frames
         // write strobe leads, select falls last and rises first
         assign ce_d = !(st_nxt == SC_RD_ACC || st_nxt == SC_WR_PULSE);
         assign we_d = !(st_nxt == SC_WR_LEAD || st_nxt == SC_WR_PULSE ||
                         st_nxt == SC_WR_HOLD);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n <= 1'b1;
         oe_n <= 1'b1;
         we_n <= 1'b1;
      end else begin
         ce_n <= ce_d;
         oe_n <= oe_d;
         we_n <= we_d;
      end
   end

   AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n); // R5

endmodule

// File: rtl/sram_dbus.sv
module sram_dbus
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  sc_state_e         st_nxt,
   input  logic              rd_sample,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   output logic [DATA_W-1:0] rdata
);

   logic drv_d;
   assign drv_d = (st_nxt == SC_WR_LEAD) || (st_nxt == SC_WR_PULSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
         rdata      <= '0;
      end else begin
         if (req_fire) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         mem_dq_oe <= drv_d;
         if (rd_sample) rdata <= mem_dq_in;
      end
   end

   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R6

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 11,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_CYCLE_NS    = 70,
   parameter int T_AA_NS       = 70,
   parameter int T_ACE_NS      = 70,
   parameter int T_AOE_NS      = 35,
   parameter int T_WP_NS       = 50,
   parameter int T_DS_NS       = 30,
   parameter int T_DH_NS       = 5,
   parameter int T_HZ_NS       = 25,
   parameter int T_REC_NS      = 10,
   parameter bit WE_CONTROLLED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int CYC_RC    = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
   localparam int ACC_CYC   = imax(imax(ns_to_cyc(T_AA_NS,  CLK_PERIOD_NS),
                                        ns_to_cyc(T_ACE_NS, CLK_PERIOD_NS)),
                                   ns_to_cyc(T_AOE_NS, CLK_PERIOD_NS));
   localparam int PULSE_CYC = imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
   localparam int HOLD_CYC  = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
   localparam int REC_CYC   = ns_to_cyc(T_REC_NS, CLK_PERIOD_NS);
   localparam int HZ_CYC    = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
   localparam int RD_REC    = imax(imax(REC_CYC, HZ_CYC), CYC_RC - ACC_CYC);
   localparam int WR_REC    = imax(REC_CYC, CYC_RC - 1 - PULSE_CYC - HOLD_CYC);
   localparam int MAX_CYC   = imax(imax(ACC_CYC, PULSE_CYC),
                                   imax(imax(HOLD_CYC, RD_REC), WR_REC));
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_cycle_ctrl: address and data widths must be positive");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("sram_cycle_ctrl: clock period must be at least 1 ns");
      end
   endgenerate

   sc_state_e        st_q, st_nxt;
   logic             req_fire, tmr_load, tmr_zero, rd_sample, ack_nxt;
   logic [CNT_W-1:0] tmr_val;

   sram_seq_fsm #(
      .ACC_CYC    (ACC_CYC),
      .PULSE_CYC  (PULSE_CYC),
      .HOLD_CYC   (HOLD_CYC),
      .RD_REC_CYC (RD_REC),
      .WR_REC_CYC (WR_REC),
      .CNT_W      (CNT_W)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_zero  (tmr_zero),
      .st_q      (st_q),
      .st_nxt    (st_nxt),
      .req_fire  (req_fire),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .rd_sample (rd_sample),
      .ack_nxt   (ack_nxt)
   );

   sram_phase_tmr #(.CNT_W(CNT_W)) i_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sram_strobe_gen #(.WE_CONTROLLED(WE_CONTROLLED)) i_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .st_nxt (st_nxt),
      .ce_n   (mem_ce_n),
      .oe_n   (mem_oe_n),
      .we_n   (mem_we_n)
   );

   sram_dbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dbus (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_fire   (req_fire),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .st_nxt     (st_nxt),
      .rd_sample  (rd_sample),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .rdata      (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack <= 1'b0;
      else        ack <= ack_nxt;
   end

   assign busy = (st_q != SC_IDLE);

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R5
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R8
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R11

endmodule

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;

   localparam int TB_CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + TB_CLK_PERIOD - 1) / TB_CLK_PERIOD;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_RC    = cyc(70);
   localparam int E_ACC   = mx(mx(cyc(70), cyc(70)), cyc(35));
   localparam int E_PULSE = mx(cyc(50), cyc(30));
   localparam int E_HOLD  = cyc(5);
   localparam int E_RREC  = mx(mx(cyc(10), cyc(25)), E_RC - E_ACC);
   localparam int E_WREC  = mx(cyc(10), E_RC - 1 - E_PULSE - E_HOLD);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic busy, ack, ce_n, oe_n, we_n, dq_oe;
   logic [DW-1:0] rdata, dq_out, dq_in;
   logic [AW-1:0] maddr;

   always #(TB_CLK_PERIOD/2) clk = ~clk;

   sram_cycle_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(TB_CLK_PERIOD),
      .T_CYCLE_NS(70), .T_AA_NS(70), .T_ACE_NS(70), .T_AOE_NS(35),
      .T_WP_NS(50), .T_DS_NS(30), .T_DH_NS(5), .T_HZ_NS(25),
      .T_REC_NS(10), .WE_CONTROLLED(1'b1)
   ) i_sram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ack(ack),
      .rdata(rdata), .mem_addr(maddr), .mem_ce_n(ce_n), .mem_oe_n(oe_n),
      .mem_we_n(we_n), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
   );

   // memory model
   logic [DW-1:0] mem [DEPTH];
   logic          wr_open = 1'b0;
   logic [AW-1:0] wr_a;
   logic [DW-1:0] wr_d;
   int            fights = 0;

   assign dq_in = (!ce_n && !oe_n && we_n) ? mem[maddr] : 8'h00;

   always @(negedge clk) begin
      if (dq_oe && !oe_n) fights++;
      if (!ce_n && !we_n) begin
         wr_open <= 1'b1;
         wr_a    <= maddr;
         wr_d    <= dq_out;
      end else if (wr_open) begin
         mem[wr_a] <= wr_d;
         wr_open   <= 1'b0;
      end
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input bit wr, input int a, input logic [DW-1:0] d,
                         input logic [DW-1:0] exp_rd, input bit intf);
      int n_end;
      logic [5:0] ev, ov, bad_o, bad_e;
      bit tim_ok, adr_ok, dat_ok, rd_ok;
      int bad_a, bad_d, got_rd;
      tim_ok = 1; adr_ok = 1; dat_ok = 1; rd_ok = 1;
      bad_o = '0; bad_e = '0; bad_a = 0; bad_d = 0; got_rd = 0;
      n_end = wr ? (1 + E_PULSE + E_HOLD + E_WREC) : (E_ACC + E_RREC);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i <= n_end; i++) begin
         if (i > 0) @(negedge clk);
         if (intf) begin
            if (i == 1) begin
               req_valid = 1'b1; req_write = 1'b1;
               req_addr = AW'(a ^ 1); req_wdata = ~d;
            end
            if (i == n_end - 1) req_valid = 1'b0;
         end
         if (wr) begin
            ev[5] = !(i <= E_PULSE + E_HOLD);            // ce_n
            ev[4] = 1'b1;                                // oe_n
            ev[3] = !(i >= 1 && i <= E_PULSE);           // we_n
            ev[2] = (i <= E_PULSE);                      // drive
            ev[1] = (i < n_end);                         // busy
            ev[0] = (i == E_PULSE + 1);                  // ack
         end else begin
            ev[5] = !(i < E_ACC);
            ev[4] = !(i < E_ACC);
            ev[3] = 1'b1;
            ev[2] = 1'b0;
            ev[1] = (i < n_end);
            ev[0] = (i == E_ACC);
         end
         ov = {ce_n, oe_n, we_n, dq_oe, busy, ack};
         if (ov !== ev && tim_ok) begin tim_ok = 0; bad_o = ov; bad_e = ev; end
         if (i < n_end && maddr !== AW'(a) && adr_ok) begin adr_ok = 0; bad_a = int'(maddr); end
         if (wr && i <= E_PULSE && dq_out !== d && dat_ok) begin dat_ok = 0; bad_d = int'(dq_out); end
         if (!wr && i == E_ACC) begin got_rd = int'(rdata); rd_ok = (rdata === exp_rd); end
      end
      if (wr) chk(tim_ok, "R4 R7 R8 R10 R11 write strobe/drive/busy/ack", int'(bad_o), int'(bad_e));
      else    chk(tim_ok, "R2 R8 R10 R11 read strobe/busy/ack", int'(bad_o), int'(bad_e));
      chk(adr_ok, "R6 address held", bad_a, a);
      if (wr) chk(dat_ok, "R6 write data held", bad_d, int'(d));
      else    chk(rd_ok, "R3 read data", got_rd, int'(exp_rd));
      if (intf) begin
         @(negedge clk);
         chk(!busy && ce_n, "R9 request during busy ignored", int'(busy), 0);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 37 + 5) & 8'hFF);
   endfunction

   initial begin
      for (int a = 0; a < DEPTH; a++) mem[a] = DW'(a) ^ 8'hA5;
      repeat (3) @(negedge clk);
      chk({ce_n, oe_n, we_n, dq_oe, busy, ack} == 6'b111000,
          "R1 state during reset", int'({ce_n, oe_n, we_n, dq_oe, busy, ack}), 'h38);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({ce_n, oe_n, we_n, dq_oe, busy, ack} == 6'b111000,
          "R1 state after reset", int'({ce_n, oe_n, we_n, dq_oe, busy, ack}), 'h38);
      // sweep: read initial contents
      for (int a = 0; a < DEPTH; a++) run_op(1'b0, a, 8'h00, DW'(a) ^ 8'hA5, 1'b0);
      // sweep: write a pattern, then read it back
      for (int a = 0; a < DEPTH; a++) run_op(1'b1, a, pat(a), 8'h00, 1'b0);
      for (int a = DEPTH - 1; a >= 0; a--) run_op(1'b0, a, 8'h00, pat(a), 1'b0);
      // back-to-back write then read of the extreme addresses
      run_op(1'b1, DEPTH - 1, 8'hFF, 8'h00, 1'b0);
      run_op(1'b0, DEPTH - 1, 8'h00, 8'hFF, 1'b0);
      run_op(1'b1, 0, 8'h00, 8'h00, 1'b0);
      run_op(1'b0, 0, 8'h00, 8'h00, 1'b0);
      // requests while busy: the write to address 7 must never happen
      run_op(1'b0, 6, 8'h5A, pat(6), 1'b1);
      run_op(1'b0, 7, 8'h00, pat(7), 1'b0); // R9 memory untouched
      run_op(1'b1, 8, 8'h3C, 8'h00, 1'b1);
      run_op(1'b0, 9, 8'h00, pat(9), 1'b0); // R9 memory untouched
      run_op(1'b0, 8, 8'h00, 8'h3C, 1'b0);
      chk(fights == 0, "R5 no drive while output enable low", fights, 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule